// File: doc/BRIEF.md
# Descriptor Fetch Engine with Lane Select

This block reads fixed-layout descriptors out of system memory for a network controller and copies their 16-bit fields into its own registers and into a small station-address CAM. It is started with a one-cycle command (load CAM, read receive resource, fetch transmit descriptor). It then walks the descriptor through a simple read port with address, request, grant and read data, raises `done` for one clock and returns to idle.

Two settings decide where each field sits in memory. `cfg_wide` selects a 16-bit or 32-bit data path, giving a width factor w of 1 or 2. `strap_be` selects big- or little-endian bus ordering. Field n of a descriptor is read from 16-bit slot n*w in little-endian mode and from slot n*w+w-1 in big-endian mode. On a 32-bit path the engine picks the half of the returned word that holds that slot. Both settings are captured when a command is accepted. The interrupt line is the OR of the bitwise AND of the mask and status inputs.

Top module: `desc_fetch`

## Requirements
- R1: Field n of a descriptor at base address B is requested at byte address B + 2*(n*w) in little-endian mode, with w = 1 when `cfg_wide` is 0 and w = 2 when it is 1. Consecutive fields are therefore 2*w bytes apart.
- R2: In big-endian mode (`strap_be` = 1), field n is requested at byte address B + 2*(n*w + w - 1). With w = 1 this is the same address as in little-endian mode.
- R3: On the 16-bit path the field is taken from `mem_rdata[15:0]`. On the 32-bit path it is taken from `mem_rdata[31:16]` when (address bit 1 XOR `strap_be`) is 1, and from `mem_rdata[15:0]` otherwise.
- R4: Command code 1 loads CAM entries. Each entry is four fields. Bits 3:0 of field 0 give the CAM index. Fields 1, 2 and 3 fill `cam_entry` bits 15:0, 31:16 and 47:32 at that index, so the low byte of field 1 is address byte 0. Entries follow each other every 8*w bytes.
- R5: A CAM load reads `cam_count` entries. It then reads one more record, whose field 0 becomes `cam_enable`. With `cam_count` = 0, only that enable record is read.
- R6: Command code 2 reads four fields into `rx_buf_addr` low half, `rx_buf_addr` high half, `rx_word_cnt` low half and `rx_word_cnt` high half, in that order.
- R7: Command code 3 reads six fields: control, packet size, fragment count, fragment address low, fragment address high and fragment size. Only bits 15:12 of the control field are kept, in `tx_ctrl`.
- R8: `irq` is 1 exactly when `int_mask & int_status` is nonzero.
- R9: `done` is high for exactly one clock after the last field of a command is granted. A command presented while `busy` is 1, or with code 0, is ignored.
- R10: `mem_req` is 0 while the engine is idle. While a request waits for `mem_gnt`, its address is held unchanged.
- R11: All registers, all CAM entries, `cam_enable`, `busy`, `done` and `mem_req` are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_be | input | 1 | Bus ordering: 1 big-endian, 0 little-endian |
| cfg_wide | input | 1 | Data path: 1 for 32-bit, 0 for 16-bit |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 load CAM, 2 receive resource, 3 transmit descriptor |
| cmd_base | input | AW | Descriptor byte address |
| cam_count | input | CW | Number of CAM entries to load |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| cam_sel | input | IW | CAM read index |
| cam_entry | output | 48 | Station address at `cam_sel` |
| cam_enable | output | 16 | CAM enable mask |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_word_cnt | output | 32 | Receive buffer word count |
| tx_ctrl | output | 4 | Transmit control bits 15:12 |
| tx_pkt_size | output | 16 | Transmit packet size |
| tx_frag_cnt | output | 16 | Transmit fragment count |
| tx_frag_addr | output | 32 | Transmit fragment address |
| tx_frag_size | output | 16 | Transmit fragment size |
| int_mask | input | 16 | Interrupt mask |
| int_status | input | 16 | Interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
Receive-resource reads run under all four width and ordering combinations against a memory model that packs 16-bit slots into 32-bit words the way each bus ordering does. Each run compares both the requested addresses and the loaded values. Swapping a lane or offset then shows up as a wrong address, as junk from the unused upper half on the 16-bit path, or as the neighbouring slot. A base address offset by two bytes on the 32-bit path forces the upper half to be selected, which separates a correct address-based lane choice from a fixed one. CAM loads with zero, one and two entries, a transmit fetch whose control field has low bits set, and a command presented while busy cover entry stepping, the enable record, field masking and command rejection.

// File: rtl/desc_fetch.sv
module desc_fetch #(
  parameter int AW    = 16,
  parameter int CAM_N = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strap_be,
  input  logic                        cfg_wide,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [AW-1:0]               cmd_base,
  input  logic [$clog2(CAM_N+1)-1:0]  cam_count,
  output logic                        busy,
  output logic                        done,
  output logic                        mem_req,
  output logic [AW-1:0]               mem_addr,
  input  logic                        mem_gnt,
  input  logic [31:0]                 mem_rdata,
  input  logic [$clog2(CAM_N)-1:0]    cam_sel,
  output logic [47:0]                 cam_entry,
  output logic [15:0]                 cam_enable,
  output logic [31:0]                 rx_buf_addr,
  output logic [31:0]                 rx_word_cnt,
  output logic [3:0]                  tx_ctrl,
  output logic [15:0]                 tx_pkt_size,
  output logic [15:0]                 tx_frag_cnt,
  output logic [31:0]                 tx_frag_addr,
  output logic [15:0]                 tx_frag_size,
  input  logic [15:0]                 int_mask,
  input  logic [15:0]                 int_status,
  output logic                        irq
);
  localparam int IW = $clog2(CAM_N);
  localparam int CW = $clog2(CAM_N + 1);
  localparam logic [1:0] OP_CAM = 2'd1;
  localparam logic [1:0] OP_RX  = 2'd2;
  localparam logic [1:0] OP_TX  = 2'd3;

  logic          act, wide_q, be_q, mask_ph, done_q;
  logic [1:0]    op_q;
  logic [AW-1:0] base_q;
  logic [2:0]    fld;
  logic [CW-1:0] left;
  logic [IW-1:0] idx_q;
  logic [47:0]   cam [CAM_N];

  wire [AW-1:0] slot  = wide_q ? AW'({fld, be_q}) : AW'(fld);
  assign mem_addr     = base_q + {slot[AW-2:0], 1'b0};
  wire          hi_sel = wide_q & (mem_addr[1] ^ be_q);
  wire [15:0]   fv    = hi_sel ? mem_rdata[31:16] : mem_rdata[15:0];
  wire          last  = mask_ph | (op_q == OP_TX ? fld == 3'd5 : fld == 3'd3);
  wire          take  = act & mem_gnt;
  wire          fin   = take & last & (mask_ph | op_q != OP_CAM);
  wire          start = cmd_valid & ~act & (cmd_op != 2'd0);
  wire [AW-1:0] rec_step = wide_q ? AW'(16) : AW'(8);

  assign busy      = act;
  assign done      = done_q;
  assign mem_req   = act;
  assign cam_entry = cam[cam_sel];
  assign irq       = |(int_mask & int_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; wide_q <= 1'b0; be_q <= 1'b0; mask_ph <= 1'b0;
      done_q <= 1'b0; op_q <= 2'd0; base_q <= '0; fld <= '0;
      left <= '0; idx_q <= '0;
    end else begin
      done_q <= fin;
      if (start) begin
        act     <= 1'b1;
        op_q    <= cmd_op;
        base_q  <= cmd_base;
        wide_q  <= cfg_wide;
        be_q    <= strap_be;
        fld     <= '0;
        left    <= cam_count;
        mask_ph <= (cmd_op == OP_CAM) && (cam_count == '0);
      end else if (take) begin
        if (op_q == OP_CAM && !mask_ph && fld == 3'd0) idx_q <= fv[IW-1:0];
        if (!last) begin
          fld <= fld + 3'd1;
        end else if (fin) begin
          act     <= 1'b0;
          mask_ph <= 1'b0;
        end else begin
          fld    <= '0;
          base_q <= base_q + rec_step;
          left   <= left - CW'(1);
          if (left == CW'(1)) mask_ph <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CAM_N; i++) cam[i] <= '0;
      cam_enable <= '0;
    end else if (take && op_q == OP_CAM) begin
      if (mask_ph) cam_enable <= fv;
      else begin
        case (fld)
          3'd1: cam[idx_q][15:0]  <= fv;
          3'd2: cam[idx_q][31:16] <= fv;
          3'd3: cam[idx_q][47:32] <= fv;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf_addr <= '0; rx_word_cnt <= '0;
    end else if (take && op_q == OP_RX) begin
      case (fld)
        3'd0: rx_buf_addr[15:0]  <= fv;
        3'd1: rx_buf_addr[31:16] <= fv;
        3'd2: rx_word_cnt[15:0]  <= fv;
        3'd3: rx_word_cnt[31:16] <= fv;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ctrl <= '0; tx_pkt_size <= '0; tx_frag_cnt <= '0;
      tx_frag_addr <= '0; tx_frag_size <= '0;
    end else if (take && op_q == OP_TX) begin
      case (fld)
        3'd0: tx_ctrl             <= fv[15:12];
        3'd1: tx_pkt_size         <= fv;
        3'd2: tx_frag_cnt         <= fv;
        3'd3: tx_frag_addr[15:0]  <= fv;
        3'd4: tx_frag_addr[31:16] <= fv;
        3'd5: tx_frag_size        <= fv;
        default: ;
      endcase
    end
  end

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_gnt) && !busy);

  // R5
  enable_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cam_enable) |-> $past(mem_gnt && mem_req));

  // R7
  tx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_frag_size) |-> $past(mem_gnt) && done);
endmodule

// File: tb/tb_desc_fetch.sv
module tb_desc_fetch;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic strap_be = 0, cfg_wide = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [15:0] cmd_base = 0;
  logic [4:0] cam_count = 0;
  logic busy, done, mem_req, mem_gnt;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [3:0] cam_sel = 0;
  logic [47:0] cam_entry;
  logic [15:0] cam_enable;
  logic [31:0] rx_buf_addr, rx_word_cnt, tx_frag_addr;
  logic [3:0] tx_ctrl;
  logic [15:0] tx_pkt_size, tx_frag_cnt, tx_frag_size;
  logic [15:0] int_mask = 0, int_status = 0;
  logic irq;

  desc_fetch dut (
    .clk(clk), .rst_n(rst_n), .strap_be(strap_be), .cfg_wide(cfg_wide),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_base(cmd_base), .cam_count(cam_count),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .cam_sel(cam_sel), .cam_entry(cam_entry),
    .cam_enable(cam_enable), .rx_buf_addr(rx_buf_addr), .rx_word_cnt(rx_word_cnt),
    .tx_ctrl(tx_ctrl), .tx_pkt_size(tx_pkt_size), .tx_frag_cnt(tx_frag_cnt),
    .tx_frag_addr(tx_frag_addr), .tx_frag_size(tx_frag_size),
    .int_mask(int_mask), .int_status(int_status), .irq(irq));

  logic [15:0] m [0:1023];
  logic [15:0] alog [0:255];
  int nlog = 0;
  int wt = 0;
  int nchk = 0, nerr = 0;

  function automatic logic [31:0] word_at(input logic [15:0] a);
    int s;
    s = int'(a >> 1) & 1023;
    if (!cfg_wide) return {16'hBAD0, m[s]};
    s = s & ~1;
    if (strap_be) return {m[s], m[s+1]};
    return {m[s+1], m[s]};
  endfunction

  function automatic logic [15:0] saddr(input logic [15:0] base, input int n);
    int w;
    w = cfg_wide ? 2 : 1;
    return 16'(int'(base) + 2 * (n * w + (strap_be ? w - 1 : 0)));
  endfunction

  function automatic logic [15:0] fexp(input logic [15:0] base, input int n);
    return m[int'(saddr(base, n) >> 1) & 1023];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_gnt <= 1'b0; mem_rdata <= '0; wt <= 0;
    end else begin
      mem_gnt <= 1'b0;
      if (mem_req && !mem_gnt) begin
        if (wt == 0) begin
          mem_gnt <= 1'b1; mem_rdata <= word_at(mem_addr); wt <= nlog % 3;
        end else wt <= wt - 1;
      end
      if (mem_req && mem_gnt) begin
        alog[nlog & 255] <= mem_addr;
        nlog <= nlog + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic chkeq(input string req, input logic [63:0] a, input logic [63:0] e);
    chk(a == e, req, a, e);
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] base, input logic [4:0] cnt);
    int t;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_base = base; cam_count = cnt;
    @(negedge clk);
    cmd_valid = 0;
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    chkeq("R9 done seen", done, 1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chkeq("R9 done one cycle", done, 0);
    chkeq("R10 port idle", mem_req, 0);
  endtask

  task automatic t_reset;
    chkeq("R11 busy", busy, 0);
    chkeq("R11 mem_req", mem_req, 0);
    chkeq("R11 done", done, 0);
    chkeq("R11 cam_enable", cam_enable, 0);
    chkeq("R11 rx", {rx_buf_addr, rx_word_cnt}, 0);
    chkeq("R11 cam", cam_entry, 0);
  endtask

  task automatic t_rx(input bit wide, input bit be, input logic [15:0] base, input string tag);
    int st;
    @(negedge clk); cfg_wide = wide; strap_be = be;
    st = nlog;
    issue(2'd2, base, 0);
    chkeq({tag, " R6 addr count"}, nlog - st, 4);
    for (int n = 0; n < 4; n++)
      chkeq({tag, " R1 R2 field address"}, alog[(st + n) & 255], saddr(base, n));
    chkeq({tag, " R3 R6 buf addr"}, rx_buf_addr, {fexp(base, 1), fexp(base, 0)});
    chkeq({tag, " R3 R6 word cnt"}, rx_word_cnt, {fexp(base, 3), fexp(base, 2)});
    after_done();
  endtask

  task automatic t_tx(input bit wide, input bit be, input logic [15:0] base);
    int st;
    @(negedge clk); cfg_wide = wide; strap_be = be;
    m[int'(saddr(base, 0) >> 1)] = 16'hA5FF;
    st = nlog;
    issue(2'd3, base, 0);
    chkeq("R7 addr count", nlog - st, 6);
    for (int n = 0; n < 6; n++)
      chkeq("R7 R2 field address", alog[(st + n) & 255], saddr(base, n));
    chkeq("R7 ctrl top bits", tx_ctrl, 4'hA);
    chkeq("R7 pkt size", tx_pkt_size, fexp(base, 1));
    chkeq("R7 frag cnt", tx_frag_cnt, fexp(base, 2));
    chkeq("R7 frag addr", tx_frag_addr, {fexp(base, 4), fexp(base, 3)});
    chkeq("R7 frag size", tx_frag_size, fexp(base, 5));
    after_done();
  endtask

  task automatic t_cam(input bit wide, input bit be, input logic [15:0] base, input int cnt);
    int st, w;
    logic [15:0] rb, mb;
    @(negedge clk); cfg_wide = wide; strap_be = be;
    w = wide ? 2 : 1;
    for (int e = 0; e < cnt; e++) begin
      rb = 16'(int'(base) + e * 8 * w);
      m[int'(saddr(rb, 0) >> 1)] = 16'(16'hFF30 | (3 * e + 5));
    end
    mb = 16'(int'(base) + cnt * 8 * w);
    st = nlog;
    issue(2'd1, base, 5'(cnt));
    chkeq("R5 addr count", nlog - st, cnt * 4 + 1);
    chkeq("R5 enable address", alog[(st + cnt * 4) & 255], saddr(mb, 0));
    chkeq("R5 enable mask", cam_enable, fexp(mb, 0));
    for (int e = 0; e < cnt; e++) begin
      rb = 16'(int'(base) + e * 8 * w);
      chkeq("R4 entry address", alog[(st + e * 4 + 3) & 255], saddr(rb, 3));
      cam_sel = 4'(3 * e + 5);
      #1;
      chkeq("R4 cam entry", cam_entry, {fexp(rb, 3), fexp(rb, 2), fexp(rb, 1)});
    end
    after_done();
  endtask

  task automatic t_busy_ignore;
    int st, t, nd;
    logic [15:0] psz;
    @(negedge clk); cfg_wide = 0; strap_be = 0;
    psz = tx_pkt_size;
    st = nlog;
    cmd_valid = 1; cmd_op = 2'd2; cmd_base = 16'h0180;
    @(negedge clk);
    cmd_op = 2'd3; cmd_base = 16'h0040;
    @(negedge clk);
    cmd_op = 2'd0; cmd_base = 16'h0060;
    @(negedge clk);
    cmd_valid = 0;
    t = 0; nd = 0;
    while (t < 40) begin if (done) nd++; @(negedge clk); t++; end
    chkeq("R9 single done", nd, 1);
    chkeq("R9 busy cmd ignored", nlog - st, 4);
    chkeq("R9 tx untouched", tx_pkt_size, psz);
    chkeq("R9 rx loaded", rx_buf_addr, {fexp(16'h0180, 1), fexp(16'h0180, 0)});
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd0; cmd_base = 16'h0010;
    @(negedge clk);
    cmd_valid = 0;
    chkeq("R9 op zero ignored", busy, 0);
    chkeq("R10 idle after op zero", mem_req, 0);
  endtask

  task automatic t_irq;
    @(negedge clk); int_mask = 16'h00F0; int_status = 16'h0F0F; #1;
    chkeq("R8 disjoint", irq, 0);
    int_status = 16'h0010; #1;
    chkeq("R8 overlap", irq, 1);
    int_mask = 16'h0000; int_status = 16'hFFFF; #1;
    chkeq("R8 masked", irq, 0);
    int_mask = 16'h8000; #1;
    chkeq("R8 top bit", irq, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) m[i] = 16'(i * 16'h1357 + 16'h0A0B);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_rx(0, 0, 16'h0100, "LE16");
    t_rx(1, 0, 16'h0200, "LE32");
    t_rx(1, 1, 16'h0200, "BE32");
    t_rx(0, 1, 16'h0120, "BE16");
    t_rx(1, 0, 16'h0302, "LE32 odd half");
    t_rx(1, 1, 16'h0322, "BE32 odd half");
    t_tx(1, 1, 16'h0400);
    t_tx(0, 0, 16'h0440);
    t_cam(0, 0, 16'h0500, 2);
    t_cam(0, 0, 16'h0580, 0);
    t_cam(1, 1, 16'h0600, 1);
    t_busy_ignore();
    t_irq();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule